// File: doc/BRIEF.md
# Register Range Protection Checker

This block guards a register space against accesses that should not happen. It holds a bank of protection entries. Each entry names a base register, a window length that is a power of two, and two separate enables: one that blocks reads and one that blocks writes. Entries are loaded through a one-word write port.

Every access presented on the lookup port is compared with all entries in parallel. One cycle later the block reports whether the access is blocked, and which entry blocked it. The window of each entry is aligned to its own length. The low bits of a base that is not aligned are dropped without warning, so the window that is protected can sit below the one that was intended.

A lookup in the same cycle as an entry write sees the table as it was before that write.

Top module: `reg_range_guard`

## Requirements
- R1: While reset is held and after it is released, every entry is cleared. The first lookup after reset reports `chk_valid`=1 and `chk_blocked`=0 for any address. While reset is held, `chk_valid` and `chk_blocked` are 0.
- R2: Bit 30 of an entry word enables write blocking. A write (`acc_write`=1) to an address inside the entry's window is blocked.
- R3: Bit 29 of an entry word enables read blocking. A read (`acc_write`=0) inside the window is blocked. A write to the same window is not blocked by an entry that has only bit 29 set.
- R4: An entry with bit 30 set and bit 29 clear blocks writes but allows reads over its window.
- R5: Bits 28:24 hold log2 of the window length L. An address that is one past the window, or one below it, is not blocked.
- R6: Bits 19:2 hold the base register, which is the word address shifted left by 2. The base is masked down to a multiple of L. For example, base 0x07 with L=4 protects 0x04 to 0x07 and leaves 0x08 open.
- R7: When several entries block an access, `chk_idx` reports the lowest index among them. When the access is not blocked, `chk_idx` is 0.
- R8: `chk_valid`, `chk_blocked` and `chk_idx` are registered. They describe the access that was presented on the previous rising edge. `chk_valid` is 0 after a cycle with no access, and `chk_blocked` is then 0.
- R9: An entry with both enable bits clear protects nothing. Rewriting an entry replaces its previous contents.
- R10: A log2 length of ADDR_W or more makes the entry cover the whole register space.
- R11: An entry write whose reserved bits (31, 23:20, 1:0) are not all zero is dropped. The entry keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_data | input | 32 | Entry word |
| acc_valid | input | 1 | Access lookup request |
| acc_addr | input | ADDR_W | Register address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| chk_valid | output | 1 | A lookup result is present |
| chk_blocked | output | 1 | The access was blocked |
| chk_idx | output | IDX_W | Lowest index of the blocking entries |

## Verification
An entry write takes effect at the rising edge that captures it. A lookup result appears at the rising edge after the request and stays until the next edge. The bench changes inputs on falling edges. After each request it waits exactly one rising edge and samples the three result outputs on the next falling edge. Entry writes are always done before the lookups that depend on them, and the same-cycle case is left to its stated rule. Reset and idle results are sampled the same way: one rising edge after the condition is set.

// File: rtl/reg_range_guard.sv
module reg_range_guard #(
  parameter int NUM_ENT = 16,
  parameter int ADDR_W  = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_ENT)-1:0] cfg_idx,
  input  logic [31:0]                cfg_data,
  input  logic                       acc_valid,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       acc_write,
  output logic                       chk_valid,
  output logic                       chk_blocked,
  output logic [$clog2(NUM_ENT)-1:0] chk_idx
);
  localparam int IDX_W  = $clog2(NUM_ENT);
  localparam int BASE_LO = 2;
  localparam int BASE_HI = BASE_LO + ADDR_W - 1;

  logic              wblk_q [NUM_ENT];
  logic              rblk_q [NUM_ENT];
  logic [4:0]        lg_q   [NUM_ENT];
  logic [ADDR_W-1:0] base_q [NUM_ENT];
  logic [NUM_ENT-1:0] hit;

  wire rsvd_ok = (cfg_data[31] == 1'b0) && (cfg_data[23:BASE_HI+1] == '0) &&
                 (cfg_data[BASE_LO-1:0] == '0);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    wire [ADDR_W-1:0] mask = {ADDR_W{1'b1}} << lg_q[i];
    wire in_win = (acc_addr & mask) == (base_q[i] & mask);
    assign hit[i] = in_win && (acc_write ? wblk_q[i] : rblk_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        wblk_q[i] <= 1'b0;
        rblk_q[i] <= 1'b0;
        lg_q[i]   <= '0;
        base_q[i] <= '0;
      end else if (cfg_we && rsvd_ok && cfg_idx == IDX_W'(i)) begin
        wblk_q[i] <= cfg_data[30];
        rblk_q[i] <= cfg_data[29];
        lg_q[i]   <= cfg_data[28:24];
        base_q[i] <= cfg_data[BASE_HI:BASE_LO];
      end
    end
  end

  logic [IDX_W-1:0] first_idx;
  always_comb begin
    first_idx = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--)
      if (hit[k]) first_idx = IDX_W'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid   <= 1'b0;
      chk_blocked <= 1'b0;
      chk_idx     <= '0;
    end else begin
      chk_valid   <= acc_valid;
      chk_blocked <= acc_valid && (hit != '0);
      chk_idx     <= (acc_valid && hit != '0) ? first_idx : '0;
    end
  end
endmodule

module reg_range_guard_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             chk_valid,
  input logic             chk_blocked,
  input logic [IDX_W-1:0] chk_idx
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!chk_valid && !chk_blocked));
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> chk_valid);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!chk_valid && !chk_blocked));
  assert_blocked_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    chk_blocked |-> chk_valid);
  assert_idx_zero_open_R7: assert property (@(posedge clk) disable iff (rst)
    !chk_blocked |-> (chk_idx == '0));
endmodule

bind reg_range_guard reg_range_guard_chk #(.IDX_W($clog2(NUM_ENT))) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .chk_valid(chk_valid),
  .chk_blocked(chk_blocked), .chk_idx(chk_idx)
);

// File: tb/reg_range_guard_bench.sv
module reg_range_guard_bench;
  localparam int ADDR_W = 18;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic acc_write = 1'b0;
  logic chk_valid, chk_blocked;
  logic [IDX_W-1:0] chk_idx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reg_range_guard #(.NUM_ENT(16), .ADDR_W(ADDR_W)) u_reg_range_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .chk_valid(chk_valid), .chk_blocked(chk_blocked), .chk_idx(chk_idx)
  );

  function automatic logic [31:0] ent(input bit wb, input bit rb,
                                      input int lg, input int base);
    return {1'b0, wb, rb, 5'(lg), 4'b0, 18'(base), 2'b00};
  endfunction

  task automatic prog(input int idx, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input int addr, input bit wr, input bit exp_b,
                        input int exp_i, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = ADDR_W'(addr); acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    n_run++;
    if (chk_valid !== 1'b1 || chk_blocked !== exp_b ||
        (exp_b && chk_idx !== IDX_W'(exp_i)) || (!exp_b && chk_idx !== '0)) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0d: got v=%0d b=%0d i=%0d, exp v=1 b=%0d i=%0d",
               req, addr, wr, chk_valid, chk_blocked, chk_idx, exp_b,
               exp_b ? exp_i : 0);
    end
  endtask

  // vector: {addr[17:0], wr, exp_blocked, exp_idx[3:0]}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {18'h00104, 1'b1, 1'b1, 4'd2},  // R2 R4
    {18'h00104, 1'b0, 1'b0, 4'd0},  // R4
    {18'h0010A, 1'b0, 1'b1, 4'd5},  // R3 R7
    {18'h0010A, 1'b1, 1'b1, 4'd2},  // R7
    {18'h00110, 1'b1, 1'b0, 4'd0},  // R5
    {18'h000FF, 1'b1, 1'b0, 4'd0},  // R5
    {18'h00004, 1'b0, 1'b1, 4'd3},  // R6
    {18'h00007, 1'b1, 1'b1, 4'd3},  // R6
    {18'h00008, 1'b1, 1'b0, 4'd0},  // R6
    {18'h00003, 1'b0, 1'b0, 4'd0},  // R6
    {18'h00200, 1'b0, 1'b1, 4'd7},  // R3
    {18'h00200, 1'b1, 1'b0, 4'd0},  // R3
    {18'h00201, 1'b0, 1'b0, 4'd0}   // R5
  };

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (chk_valid !== 1'b0 || chk_blocked !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: v=%0d b=%0d, exp 0 0", chk_valid, chk_blocked);
    end
    rst = 1'b0;
    lookup(18'h00000, 1'b1, 1'b0, 0, "R1");
    lookup(18'h3FFFF, 1'b0, 1'b0, 0, "R1");

    prog(2, ent(1, 0, 4, 18'h100));
    prog(3, ent(1, 1, 2, 18'h007));
    prog(5, ent(1, 1, 3, 18'h108));
    prog(7, ent(0, 1, 0, 18'h200));

    for (int v = 0; v < NV; v++)
      lookup(int'(VEC[v][23:6]), VEC[v][5], VEC[v][4], int'(VEC[v][3:0]), "R2-table");

    @(negedge clk);
    n_run++;
    if (chk_valid !== 1'b0 || chk_blocked !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 idle: v=%0d b=%0d, exp 0 0", chk_valid, chk_blocked);
    end

    prog(3, ent(0, 0, 2, 18'h007));
    lookup(18'h00004, 1'b0, 1'b0, 0, "R9");
    lookup(18'h00007, 1'b1, 1'b0, 0, "R9");

    prog(3, 32'h4200_001C | 32'h0000_0001);
    lookup(18'h00004, 1'b1, 1'b0, 0, "R11");
    prog(3, ent(1, 0, 2, 18'h007) | 32'h0010_0000);
    lookup(18'h00007, 1'b1, 1'b0, 0, "R11");
    prog(3, ent(1, 0, 2, 18'h007) | 32'h8000_0000);
    lookup(18'h00005, 1'b1, 1'b0, 0, "R11");

    prog(15, ent(1, 1, 31, 18'h12345));
    lookup(18'h3FFFF, 1'b1, 1'b1, 15, "R10");
    lookup(18'h00000, 1'b0, 1'b1, 15, "R10");
    lookup(18'h00104, 1'b1, 1'b1, 2, "R7");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule